// File: doc/BRIEF.md
# One-Shot Delayed Pulse Timer

The block makes exactly one output pulse each time it is started by a write to its control register. A 16-bit up-counter, clocked through a selectable divider, counts from zero to a programmed end value and then stops. While it counts, a match against a programmed threshold can set a channel output. The end-of-count event can clear it. Each of the two channels has its own routing and output gate.

Software stops the timer with the enable bit before it writes the divider, the end value, the threshold or the routing. It then sets enable again and issues start strobes. An end value outside the legal range is forced into that range, and a sticky flag records the fault.

Top module: `oneshot_pulse_timer`

## Requirements
- R1: After reset both channel outputs and the range-fault flag are low. The defaults are divide-by-1, end value 3, threshold 0 and all routing off.
- R2: Let P be the end value, C the threshold and D the divide ratio. When a start is accepted at clock edge 0, a channel routed for both set and clear rises at edge (C+1)·D and falls at edge (P+1)·D, provided C < P. The counter then halts, and no further pulse appears without a new start.
- R3: Register 1, bits [3:0], hold the divider code. Code 5 divides by 1, code 6 by 2 and code 8 by 4. Every other code divides by 1.
- R4: Register 4 holds a 4-bit field per channel, where channel i uses bits [4i+2:4i]. Bit 4i enables set-on-threshold, bit 4i+1 enables clear-on-end and bit 4i+2 gates the pin. With set off, the output never rises. With clear off, it stays high once set. With the gate off, the pin stays low.
- R5: If threshold equals the end value, the clear wins and the output stays low. If threshold is above the end value, no set ever happens.
- R6: Register 0, bit 0, is the enable. While enable is low the outputs are forced low from the second edge after the write. A start strobe is ignored, and setting enable alone does not start a count.
- R7: A start is a write to register 0 with bits 0 and 1 set while enable is already high. A start during a pulse restarts the count from zero, and the output keeps its level until the next set or clear event.
- R8: Writes to registers 1 to 4 while enable is high are ignored.
- R9: An end-value write below 3 stores 3, and one above 0xFFDE stores 0xFFDE. Either case sets the range-fault flag. The flag stays set until a write to register 0 with bit 2 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| ch_out | output | 2 | Channel output pins |
| range_err | output | 1 | Sticky end-value range fault |

## Verification
Every result is counted in clock edges from the edge that captures the start write. The rise is due at edge (C+1)·D and the fall at edge (P+1)·D. Both can be computed in closed form from the written configuration.

The bench samples at each falling edge after that write and compares with those formulas for every edge of the window, on both channels. It does the same after a restart, where the fall is due (P+1)·D edges after the restarting write. Disabling has an effect from the second edge after the write, and flag changes show at the first falling edge after their write. The checks sample there.

// File: rtl/otm_pkg.sv
package otm_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV   = 3'd1;
  localparam logic [ADDR_W-1:0] A_END   = 3'd2;
  localparam logic [ADDR_W-1:0] A_THR   = 3'd3;
  localparam logic [ADDR_W-1:0] A_ROUTE = 3'd4;

  // divider code -> log2 of divide ratio (code = ratio + 4)
  function automatic logic [1:0] code_to_shift(input logic [3:0] code);
    case (code)
      4'd6:    return 2'd1;
      4'd8:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/otm_regs.sv
module otm_regs
  import otm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              en,
  output logic              start,
  output logic [1:0]        div_sh,
  output logic [CNT_W-1:0]  end_val,
  output logic [CNT_W-1:0]  thr_val,
  output logic [NUM_CH-1:0] set_sel,
  output logic [NUM_CH-1:0] clr_sel,
  output logic [NUM_CH-1:0] pin_gate,
  output logic              err
);
  localparam logic [CNT_W-1:0] END_MIN = CNT_W'(3);
  localparam logic [CNT_W-1:0] END_MAX = CNT_W'((1 << CNT_W) - 34);

  logic cfg_wr;
  assign cfg_wr = wr_en && !en;
  assign start  = wr_en && (wr_addr == A_CTRL) && wr_data[0] && wr_data[1] && en;

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      err      <= 1'b0;
      div_sh   <= 2'd0;
      end_val  <= END_MIN;
      thr_val  <= '0;
      set_sel  <= '0;
      clr_sel  <= '0;
      pin_gate <= '0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) begin
        en <= wr_data[0];
        if (wr_data[2]) err <= 1'b0;
      end
      if (cfg_wr && wr_addr == A_DIV) div_sh <= code_to_shift(wr_data[3:0]);
      if (cfg_wr && wr_addr == A_THR) thr_val <= wr_data;
      if (cfg_wr && wr_addr == A_END) begin
        if (wr_data < END_MIN) begin
          end_val <= END_MIN;
          err     <= 1'b1;
        end else if (wr_data > END_MAX) begin
          end_val <= END_MAX;
          err     <= 1'b1;
        end else begin
          end_val <= wr_data;
        end
      end
      if (cfg_wr && wr_addr == A_ROUTE) begin
        for (int i = 0; i < NUM_CH; i++) begin
          set_sel[i]  <= wr_data[4*i];
          clr_sel[i]  <= wr_data[4*i+1];
          pin_gate[i] <= wr_data[4*i+2];
        end
      end
    end
  end

  // R9
  end_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (end_val >= END_MIN) && (end_val <= END_MAX));
  // R8
  cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (en && wr_en && wr_addr != A_CTRL) |=> $stable(end_val) && $stable(thr_val) && $stable(div_sh));
endmodule

// File: rtl/otm_prescaler.sv
module otm_prescaler (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       restart,
  input  logic [1:0] div_sh,
  output logic       tick
);
  logic [1:0] phase;
  logic [1:0] last;

  always_comb begin
    case (div_sh)
      2'd1:    last = 2'd1;
      2'd2:    last = 2'd3;
      default: last = 2'd0;
    endcase
  end

  assign tick = en && (phase == last);

  always_ff @(posedge clk) begin
    if (rst || !en || restart || tick) phase <= 2'd0;
    else                               phase <= phase + 2'd1;
  end

  // R3
  tick_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (restart || !en) |=> (phase == 2'd0));
endmodule

// File: rtl/otm_counter.sv
module otm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             tick,
  input  logic [CNT_W-1:0] end_val,
  input  logic [CNT_W-1:0] thr_val,
  output logic             thr_evt,
  output logic             end_evt
);
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic             step;

  assign step    = running && tick && !start;
  assign thr_evt = step && (cnt == thr_val);
  assign end_evt = step && (cnt == end_val);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start) begin
      cnt     <= '0;
      running <= 1'b1;
    end else if (step) begin
      if (cnt == end_val) running <= 1'b0;
      else                cnt     <= cnt + 1'b1;
    end
  end

  // R2
  halt_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    end_evt |=> !running);
  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !tick && !start) |=> $stable(cnt));
  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt == '0) && running);
endmodule

// File: rtl/otm_channel.sv
module otm_channel (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic thr_evt,
  input  logic end_evt,
  input  logic set_sel,
  input  logic clr_sel,
  input  logic pin_gate,
  output logic pin
);
  logic level;

  always_ff @(posedge clk) begin
    if (rst || !en)                level <= 1'b0;
    else if (end_evt && clr_sel)   level <= 1'b0;
    else if (thr_evt && set_sel)   level <= 1'b1;
  end

  assign pin = level && pin_gate;

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (en && end_evt && clr_sel) |=> !level);
  // R6
  disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !level);
  // R4
  no_set_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!level && !(thr_evt && set_sel)) |=> !level);
endmodule

// File: rtl/oneshot_pulse_timer.sv
module oneshot_pulse_timer
  import otm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [15:0]       wr_data,
  output logic [1:0]        ch_out,
  output logic              range_err
);
  logic              en, start, tick, thr_evt, end_evt;
  logic [1:0]        div_sh;
  logic [CNT_W-1:0]  end_val, thr_val;
  logic [NUM_CH-1:0] set_sel, clr_sel, pin_gate, pins;

  otm_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(CNT_W'(wr_data)), .en(en), .start(start), .div_sh(div_sh),
    .end_val(end_val), .thr_val(thr_val), .set_sel(set_sel),
    .clr_sel(clr_sel), .pin_gate(pin_gate), .err(range_err)
  );

  otm_prescaler u_presc (
    .clk(clk), .rst(rst), .en(en), .restart(start), .div_sh(div_sh), .tick(tick)
  );

  otm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .start(start), .tick(tick),
    .end_val(end_val), .thr_val(thr_val), .thr_evt(thr_evt), .end_evt(end_evt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    otm_channel u_ch (
      .clk(clk), .rst(rst), .en(en), .thr_evt(thr_evt), .end_evt(end_evt),
      .set_sel(set_sel[i]), .clr_sel(clr_sel[i]), .pin_gate(pin_gate[i]),
      .pin(pins[i])
    );
  end

  assign ch_out = 2'(pins);

  // R6
  outputs_off_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(en) |=> ##1 (ch_out == 2'b00));
endmodule

// File: tb/oneshot_pulse_timer_bench.sv
module oneshot_pulse_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  ch_out;
  logic        range_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  oneshot_pulse_timer u_oneshot_pulse_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ch_out(ch_out), .range_err(range_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ratio_of(input int code);
    case (code)
      6: return 2;
      8: return 4;
      default: return 1;
    endcase
  endfunction

  // expected pin level n edges after the start edge
  function automatic bit exp_pin(input int n, input int thr, input int endv,
                                 input int d, input bit s, input bit c, input bit g);
    if (!g || !s || thr > endv) return 1'b0;
    if (n < (thr + 1) * d) return 1'b0;
    if (!c) return 1'b1;
    if (thr == endv) return 1'b0;
    return (n < (endv + 1) * d);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic configure(input int code, input int endv, input int thr, input int route);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'(code));
    wr(3'd2, 16'(endv));
    wr(3'd3, 16'(thr));
    wr(3'd4, 16'(route));
    wr(3'd0, 16'h0001);
  endtask

  task automatic watch(input string req, input int code, input int endv,
                       input int thr, input int route, input int span);
    int d = ratio_of(code);
    for (int n = 0; n <= span; n++) begin
      for (int ch = 0; ch < 2; ch++) begin
        bit e = exp_pin(n, thr, endv, d, route[4*ch], route[4*ch+1], route[4*ch+2]);
        check(req, ch_out[ch], e);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int codes[4] = '{5, 6, 8, 5};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1", ch_out, 0);
    check("R1", range_err, 0);

    // R2 directed, divide by 2
    configure(6, 8, 3, 16'h0077);
    wr(3'd0, 16'h0003);
    watch("R2", 6, 8, 3, 16'h0077, 30);

    // R3 odd code divides by 1; code 8 divides by 4
    configure(7, 6, 2, 16'h0003 | 16'h0070);
    wr(3'd0, 16'h0003);
    watch("R3", 5, 6, 2, 16'h0073, 12);
    configure(8, 5, 1, 16'h0007);
    wr(3'd0, 16'h0003);
    watch("R3", 8, 5, 1, 16'h0007, 30);

    // R5 threshold equal to end, threshold above end
    configure(5, 6, 6, 16'h0077);
    wr(3'd0, 16'h0003);
    watch("R5", 5, 6, 6, 16'h0077, 12);
    configure(5, 6, 9, 16'h0057);
    wr(3'd0, 16'h0003);
    watch("R5", 5, 6, 9, 16'h0057, 14);

    // R4 routing variants: no clear, no set, no gate
    configure(5, 5, 2, 16'h0035);
    wr(3'd0, 16'h0003);
    watch("R4", 5, 5, 2, 16'h0035, 14);

    // random mix (R2 / R4 / R5 by case)
    for (int k = 0; k < 24; k++) begin
      int code  = codes[$urandom_range(0, 3)];
      int endv  = $urandom_range(3, 30);
      int thr   = $urandom_range(0, 34);
      int route = ($urandom_range(0, 7) << 4) | $urandom_range(0, 7);
      string tag = (thr >= endv) ? "R5" : ((route & 16'h0077) != 16'h0077) ? "R4" : "R2";
      configure(code, endv, thr, route);
      wr(3'd0, 16'h0003);
      watch(tag, code, endv, thr, route, (endv + 3) * ratio_of(code));
    end

    // R7 restart during pulse
    configure(5, 10, 2, 16'h0007);
    wr(3'd0, 16'h0003);
    repeat (5) @(negedge clk);
    check("R7", ch_out[0], 1);
    wr(3'd0, 16'h0003);
    for (int n = 0; n <= 13; n++) begin
      check("R7", ch_out[0], (n < 11) ? 1 : 0);
      @(negedge clk);
    end

    // R8 config writes while enabled are ignored
    configure(5, 10, 2, 16'h0007);
    wr(3'd3, 16'd6);
    wr(3'd2, 16'd4);
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h0003);
    watch("R8", 5, 10, 2, 16'h0007, 14);

    // R6 start ignored while disabled, enable alone does not start
    configure(5, 10, 0, 16'h0007);
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0002);
    for (int n = 0; n < 15; n++) begin check("R6", ch_out, 0); @(negedge clk); end
    wr(3'd0, 16'h0001);
    for (int n = 0; n < 15; n++) begin check("R6", ch_out, 0); @(negedge clk); end
    // R6 disable mid-pulse
    wr(3'd0, 16'h0003);
    repeat (3) @(negedge clk);
    check("R6", ch_out[0], 1);
    wr(3'd0, 16'h0000);
    @(negedge clk);
    check("R6", ch_out, 0);

    // R9 low clamp, flag, clear, high clamp
    configure(5, 1, 1, 16'h0007);
    check("R9", range_err, 1);
    wr(3'd0, 16'h0003);
    watch("R9", 5, 3, 1, 16'h0007, 8);
    check("R9", range_err, 1);
    wr(3'd0, 16'h0004);
    check("R9", range_err, 0);
    wr(3'd2, 16'd40);
    check("R9", range_err, 0);
    wr(3'd2, 16'hFFFF);
    check("R9", range_err, 1);
    wr(3'd0, 16'h0004);
    wr(3'd2, 16'hFFDE);
    check("R9", range_err, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule